// File: doc/BRIEF.md
# USB Host Channel Characteristics Register Bank

This block holds the per-channel characteristics words of a multi-channel USB host controller. Each channel has one configuration word and a small halt-status word. Both are placed at a fixed base address with a fixed stride per channel, and software reaches them over a simple register port. The configuration word holds the start bit, the stop-request bit, the odd/even frame select for periodic transfers, the 7-bit device address, and a 22-bit general parameter field. The transfer engine reads all of these through dedicated per-channel outputs.

Software fills in a channel's fields and sets the start bit to launch a transfer. Only the controller clears the start bit, and it does so when the engine reports that the channel has finished or halted. Software can request an early stop by setting the stop-request bit. It must still wait for the channel's halted flag before it treats the channel as idle. The halted flag is sticky, drives a per-channel interrupt line, and is cleared by writing 1 to it.

Top module: `usb_hchan_bank`

## Requirements
- R1: After reset, every configuration word and every halted flag is zero, and the outputs ch_run, ch_abort, ch_odd_frame, ch_dev_addr and halt_irq are all zero.
- R2: Channel n's configuration word is at byte address 0x500 + n*0x20 and its halt-status word is at 0x500 + n*0x20 + 0x08, for n from 0 to 11. In the configuration word, bit 29 is the odd-frame select, bits 28:22 are the device address and bits 21:0 are the parameter field. These three fields read back exactly as written.
- R3: Bit 31 of the configuration word is the start bit. A write with bit 31 set raises ch_run for that channel at the next clock edge. A write with bit 31 clear leaves the start bit unchanged.
- R4: Bit 30 is the stop request. Software can only set it, and writing 0 leaves it unchanged. While it is set, ch_abort for that channel is high.
- R5: A one-cycle pulse on eng_halt[n] clears both the start bit and the stop request of channel n, and sets its halted flag, at the next clock edge. This holds even if a write to that channel occurs in the same cycle.
- R6: The halted flag is bit 0 of the halt-status word and is sticky. Writing 1 to it clears it, and writing 0 has no effect. If a set and a clear arrive in the same cycle, the set wins.
- R7: A stop request that is set while the start bit is 0 sets the halted flag and clears the stop request at the following clock edge.
- R8: An address inside or outside the bank that maps to no register reads as zero. A write to such an address changes no register.
- R9: ch_odd_frame[n] and ch_dev_addr[7n+6:7n] reflect channel n's stored odd-frame bit and device address, and halt_irq[n] equals channel n's halted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eng_halt | input | 12 | Per-channel completion/halt pulse from the engine |
| ch_run | output | 12 | Per-channel start bit |
| ch_abort | output | 12 | Per-channel stop request |
| ch_odd_frame | output | 12 | Per-channel odd-frame select |
| ch_dev_addr | output | 84 | Per-channel 7-bit device addresses, channel n at bits 7n+6:7n |
| halt_irq | output | 12 | Per-channel sticky halted flag |

## Verification
A register write, an engine halt pulse and a halted-flag clear each take effect at the first clock edge after they are presented. A stop request made while the channel is idle needs one more edge before the halted flag appears. Reads are combinational and are valid a short delay after the address changes. The bench drives every input on the falling edge and samples one falling edge after the stimulus. For the idle-stop case it samples twice: once to see the request pending, and once a cycle later to see the halt. This keeps each check at the exact edge where its result becomes due.

// File: rtl/usb_hchan_pkg.sv
package usb_hchan_pkg;

   localparam int CFG_W    = 32;
   localparam int DEV_W    = 7;
   localparam int PAR_W    = 22;
   localparam int HALT_OFF = 8;

   // Field layout of one configuration word, MSB first.
   typedef struct packed {
      logic             run;
      logic             abort;
      logic             odd;
      logic [DEV_W-1:0] dev;
      logic [PAR_W-1:0] par;
   } chan_cfg_t;

endpackage

// File: rtl/usb_hchan_dec.sv
module usb_hchan_dec #(
   parameter int NUM_CH   = 12,
   parameter int ADDR_W   = 12,
   parameter int BASE     = 'h500,
   parameter int STRIDE   = 'h20,
   parameter int HALT_OFF = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] sel_cfg,
   output logic [NUM_CH-1:0] sel_halt
);
   localparam int          SH = $clog2(STRIDE);
   localparam logic [31:0] LO = 32'(BASE);
   localparam logic [31:0] HI = 32'(BASE + NUM_CH * STRIDE);

   logic [31:0] a32, rel;
   logic        in_rng;
   logic [31:0] idx;
   logic [SH-1:0] off;

   always_comb begin
      a32    = 32'(addr);
      rel    = a32 - LO;
      in_rng = (a32 >= LO) && (a32 < HI);
      idx    = rel >> SH;
      off    = rel[SH-1:0];
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign sel_cfg[g]  = in_rng && (idx == 32'(g)) && (off == '0);
      assign sel_halt[g] = in_rng && (idx == 32'(g)) && (off == SH'(HALT_OFF));
   end

endmodule

// File: rtl/usb_hchan_ch.sv
module usb_hchan_ch
   import usb_hchan_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_cfg,
   input  logic        wr_halt,
   input  logic [CFG_W-1:0] wdata,
   input  logic        eng_halt,
   output chan_cfg_t   cfg,
   output logic        halted
);
   chan_cfg_t wd;
   logic      stop;

   always_comb begin
      wd   = chan_cfg_t'(wdata);
      stop = eng_halt || (cfg.abort && !cfg.run);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         halted <= 1'b0;
      end else begin
         if (wr_cfg) begin
            cfg.odd <= wd.odd;
            cfg.dev <= wd.dev;
            cfg.par <= wd.par;
            if (wd.run)   cfg.run   <= 1'b1;
            if (wd.abort) cfg.abort <= 1'b1;
         end
         if (stop) begin
            cfg.run   <= 1'b0;
            cfg.abort <= 1'b0;
         end
         if (stop)
            halted <= 1'b1;
         else if (wr_halt && wdata[0])
            halted <= 1'b0;
      end
   end

   assert_run_by_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg.run) |-> $past(wr_cfg && wdata[CFG_W-1]));

   assert_run_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.run && wr_cfg && !wdata[CFG_W-1] && !eng_halt) |=> cfg.run);

   assert_halt_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_halt |=> (!cfg.run && !cfg.abort && halted));

   assert_idle_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.abort && !cfg.run) |=> (halted && !cfg.abort));

   assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted) |-> $past(wr_halt && wdata[0]));

endmodule

// File: rtl/usb_hchan_bank.sv
module usb_hchan_bank
   import usb_hchan_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h500,
   parameter int STRIDE = 'h20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [CFG_W-1:0]        reg_wdata,
   output logic [CFG_W-1:0]        reg_rdata,
   input  logic [NUM_CH-1:0]       eng_halt,
   output logic [NUM_CH-1:0]       ch_run,
   output logic [NUM_CH-1:0]       ch_abort,
   output logic [NUM_CH-1:0]       ch_odd_frame,
   output logic [NUM_CH*DEV_W-1:0] ch_dev_addr,
   output logic [NUM_CH-1:0]       halt_irq
);
   if (NUM_CH < 1) begin : g_bad_n
      $error("NUM_CH must be at least 1");
   end
   if ((STRIDE & (STRIDE - 1)) != 0 || STRIDE <= HALT_OFF) begin : g_bad_s
      $error("STRIDE must be a power of two above the halt offset");
   end
   if ((BASE % STRIDE) != 0) begin : g_bad_b
      $error("BASE must be aligned to STRIDE");
   end
   if (BASE + NUM_CH * STRIDE > (1 << ADDR_W)) begin : g_bad_a
      $error("bank does not fit in the address space");
   end

   logic [NUM_CH-1:0] sel_cfg, sel_halt;
   chan_cfg_t         cfg [NUM_CH];
   logic [NUM_CH-1:0] halted;

   usb_hchan_dec #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE(BASE),
      .STRIDE(STRIDE), .HALT_OFF(HALT_OFF)
   ) dec_i (
      .addr(reg_addr), .sel_cfg(sel_cfg), .sel_halt(sel_halt)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      usb_hchan_ch ch_i (
         .clk(clk), .rst_n(rst_n),
         .wr_cfg(reg_wr && sel_cfg[g]),
         .wr_halt(reg_wr && sel_halt[g]),
         .wdata(reg_wdata),
         .eng_halt(eng_halt[g]),
         .cfg(cfg[g]),
         .halted(halted[g])
      );
      assign ch_run[g]                    = cfg[g].run;
      assign ch_abort[g]                  = cfg[g].abort;
      assign ch_odd_frame[g]              = cfg[g].odd;
      assign ch_dev_addr[g*DEV_W +: DEV_W] = cfg[g].dev;
   end

   assign halt_irq = halted;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel_cfg[i])  reg_rdata = cfg[i];
         if (sel_halt[i]) reg_rdata = {{(CFG_W-1){1'b0}}, halted[i]};
      end
   end

   assert_dec_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_cfg, sel_halt}));

   assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !(|{sel_cfg, sel_halt}) && eng_halt == '0 && (ch_abort & ~ch_run) == '0)
      |=> ($stable(ch_run) && $stable(ch_abort) && $stable(ch_odd_frame)));

endmodule

// File: tb/usb_hchan_bank_tb_top.sv
`timescale 1ns/1ps
module usb_hchan_bank_tb_top;
   localparam int NCH = 12;
   localparam time CYC = 20ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [11:0]      reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [NCH-1:0]   eng_halt = '0;
   logic [NCH-1:0]   ch_run, ch_abort, ch_odd_frame, halt_irq;
   logic [NCH*7-1:0] ch_dev_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CYC/2) clk = ~clk;

   usb_hchan_bank dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_halt(eng_halt),
      .ch_run(ch_run), .ch_abort(ch_abort), .ch_odd_frame(ch_odd_frame),
      .ch_dev_addr(ch_dev_addr), .halt_irq(halt_irq)
   );

   function automatic logic [11:0] cfg_a(input int n);
      return 12'(32'h500 + n * 32'h20);
   endfunction
   function automatic logic [11:0] hlt_a(input int n);
      return 12'(32'h508 + n * 32'h20);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_halt(input int n);
      @(negedge clk);
      eng_halt[n] = 1'b1;
      @(negedge clk);
      eng_halt = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(cfg_a(0), d);  chk("R1 ch0 cfg", d, 0);
      rd(cfg_a(11), d); chk("R1 ch11 cfg", d, 0);
      chk("R1 run/abort", {ch_run, ch_abort}, 0);
      chk("R1 irq", 32'(halt_irq), 0);
      chk("R1 dev", 32'(ch_dev_addr[31:0]), 0);
   endtask

   task automatic t_fields;
      logic [31:0] d;
      wr(cfg_a(3), 32'h3540_1234);
      rd(cfg_a(3), d);  chk("R2 ch3 readback", d, 32'h3540_1234);
      chk("R9 odd3", 32'(ch_odd_frame[3]), 1);
      chk("R9 dev3", 32'(ch_dev_addr[3*7 +: 7]), 32'h55);
      chk("R3 no run on ch3", 32'(ch_run[3]), 0);
      wr(cfg_a(11), 32'h00C0_0007);
      rd(cfg_a(11), d); chk("R2 ch11 readback", d, 32'h00C0_0007);
      chk("R9 dev11", 32'(ch_dev_addr[11*7 +: 7]), 32'h03);
   endtask

   task automatic t_run;
      logic [31:0] d;
      wr(cfg_a(5), 32'h8000_0000);
      chk("R3 run set", 32'(ch_run[5]), 1);
      wr(cfg_a(5), 32'h0000_0000);
      chk("R3 write0 ignored", 32'(ch_run[5]), 1);
      rd(cfg_a(5), d); chk("R3 bit31 readback", d, 32'h8000_0000);
   endtask

   task automatic t_engine_halt;
      logic [31:0] d;
      pulse_halt(5);
      chk("R5 run cleared", 32'(ch_run[5]), 0);
      chk("R5 irq set", 32'(halt_irq[5]), 1);
      rd(hlt_a(5), d); chk("R6 halt reg", d, 1);
      wr(hlt_a(5), 0);
      chk("R6 write0 keeps", 32'(halt_irq[5]), 1);
      wr(hlt_a(5), 1);
      chk("R6 w1c clears", 32'(halt_irq[5]), 0);
   endtask

   task automatic t_abort;
      wr(cfg_a(6), 32'h8000_0000);
      wr(cfg_a(6), 32'h4000_0000);
      chk("R4 abort set", 32'(ch_abort[6]), 1);
      chk("R4 run kept", 32'(ch_run[6]), 1);
      wr(cfg_a(6), 32'h0000_0000);
      chk("R4 abort write0 ignored", 32'(ch_abort[6]), 1);
      pulse_halt(6);
      chk("R5 both cleared", {30'b0, ch_run[6], ch_abort[6]}, 0);
      chk("R5 irq6", 32'(halt_irq[6]), 1);
   endtask

   task automatic t_idle_abort;
      wr(cfg_a(7), 32'h4000_0000);
      chk("R7 pending abort", 32'(ch_abort[7]), 1);
      chk("R7 not yet halted", 32'(halt_irq[7]), 0);
      @(negedge clk);
      chk("R7 halted next cycle", 32'(halt_irq[7]), 1);
      chk("R7 abort cleared", 32'(ch_abort[7]), 0);
   endtask

   task automatic t_same_cycle;
      wr(cfg_a(2), 32'h8000_0000);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = hlt_a(2); reg_wdata = 1; eng_halt[2] = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; eng_halt = '0;
      chk("R6 set wins", 32'(halt_irq[2]), 1);
      chk("R5 run2 cleared", 32'(ch_run[2]), 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(12'h504, 32'hFFFF_FFFF);
      rd(12'h504, d);   chk("R8 hole reads 0", d, 0);
      rd(cfg_a(0), d);  chk("R8 ch0 untouched", d, 0);
      chk("R8 run0", 32'(ch_run[0]), 0);
      wr(12'h700, 32'hFFFF_FFFF);
      rd(12'h700, d);   chk("R8 above bank", d, 0);
      rd(12'h4FC, d);   chk("R8 below bank", d, 0);
      chk("R8 no run", 32'(ch_run), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_run();
      t_engine_halt();
      t_abort();
      t_idle_abort();
      t_same_cycle();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CYC * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule